// File: doc/BRIEF.md
# Level-Sensitive Dual-Output Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines into two request outputs. One is a normal request (`irq_o`) and the other is a fast request (`fiq_o`). Each output has its own enable mask. Software never writes a mask directly. It writes a one to a set offset to turn lines on, and a one to a clear offset to turn them off. Software can also raise any line itself through a soft-pending vector, which also has separate set and clear offsets. A raw view and a masked view of the pending lines can be read at any time. The masked view follows the source levels live, so a handler can service the lowest set bit and then re-read until the view reads zero.

A build-time valid mask marks which lines exist. A line that does not exist never shows as pending, whatever its input or soft bit. A second build parameter selects the secondary-controller variant. In that variant, a write to the fast-status offset loads a pass-through mask, and the chosen raw lines are forwarded straight to an upstream controller on `passthru_o`.

The register port is a simple single-cycle strobe. A write takes effect at the clock edge where it is presented. Read data appears on `rdata_o` in the cycle after the read request.

Top module: `lvl_intc`

## Requirements
- R1: After reset, both enable masks, the soft-pending vector and the pass-through mask are zero. `irq_o`, `fiq_o`, `passthru_o` and `rdata_o` are zero.
- R2: A read of byte offset 0x04 or 0x24 returns the raw vector, which is (source levels OR soft-pending bits) AND the valid mask. Bit n refers to line n.
- R3: A write to 0x08 sets exactly the normal-request enable bits whose write bits are one. A write to 0x0C clears exactly those bits. All other enable bits keep their value.
- R4: A write to 0x28 sets exactly the fast-request enable bits whose write bits are one. A write to 0x2C clears exactly those bits. All other enable bits keep their value.
- R5: A read of 0x00 returns raw AND the normal enable mask. A read of 0x20 returns raw AND the fast enable mask. Both views follow the current source levels.
- R6: A write to 0x10 sets the soft-pending bits that are one in the write data. A write to 0x14 clears them. Zero bits leave the soft-pending state unchanged.
- R7: `irq_o` is the OR of the masked normal view, and `fiq_o` is the OR of the masked fast view. Each is registered with one cycle of latency.
- R8: A line that is zero in the valid mask never appears in the raw view, in either masked view, on `passthru_o`, or in the request outputs. This holds even when its source or soft bit is high.
- R9: `rdata_o` holds the addressed value in the cycle after a read request and is zero otherwise. Reads of 0x08, 0x0C, 0x10, 0x14, 0x28, 0x2C, of unmapped offsets, and of offsets whose two low bits are not zero return zero. Writes to 0x00, 0x04 and 0x24 change nothing.
- R10: In the secondary variant, a write to 0x20 loads the pass-through mask, and `passthru_o` equals raw AND that mask one cycle later. In the primary variant, the write is ignored and `passthru_o` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_LINES | Level-sensitive interrupt source lines |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data, bit n = line n |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| passthru_o | output | N_LINES | Lines forwarded upstream (secondary variant only) |

## Verification
The bench uses an 8-line configuration in which line 5 does not exist. For each of four combinations of normal enables, fast enables, soft bits and pass-through mask, it sweeps all 256 source patterns. At every step it compares the raw view, both masked views, both request outputs and the pass-through vector with values computed arithmetically. Patterns with disjoint, overlapping and all-ones masks separate a wrong mask from a wrong OR with the soft bits. The invalid line 5 shows up any missing valid gating. Directed steps cover set/clear isolation, the one-cycle latency of `irq_o`, zero reads of write-only and misaligned offsets, and a primary-variant instance on the same bus that must ignore the pass-through write.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_IRQ_STAT,
    SEL_IRQ_RAW,
    SEL_IEN_SET,
    SEL_IEN_CLR,
    SEL_SOFT_SET,
    SEL_SOFT_CLR,
    SEL_FIQ_STAT,
    SEL_FIQ_RAW,
    SEL_FEN_SET,
    SEL_FEN_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      8'h00:   s = SEL_IRQ_STAT;
      8'h04:   s = SEL_IRQ_RAW;
      8'h08:   s = SEL_IEN_SET;
      8'h0C:   s = SEL_IEN_CLR;
      8'h10:   s = SEL_SOFT_SET;
      8'h14:   s = SEL_SOFT_CLR;
      8'h20:   s = SEL_FIQ_STAT;
      8'h24:   s = SEL_FIQ_RAW;
      8'h28:   s = SEL_FEN_SET;
      8'h2C:   s = SEL_FEN_CLR;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lvl_intc_status.sv
module lvl_intc_status #(
  parameter int unsigned          N_LINES    = 32,
  parameter logic [N_LINES-1:0]   VALID_MASK = '1
) (
  input  logic [N_LINES-1:0] src_i,
  input  logic [N_LINES-1:0] soft_i,
  input  logic [N_LINES-1:0] ien_i,
  input  logic [N_LINES-1:0] fen_i,
  input  logic [N_LINES-1:0] pt_i,
  output logic [N_LINES-1:0] raw_o,
  output logic [N_LINES-1:0] irq_st_o,
  output logic [N_LINES-1:0] fiq_st_o,
  output logic [N_LINES-1:0] pt_st_o
);
  // non-existent lines are gated before every view
  assign raw_o    = (src_i | soft_i) & VALID_MASK;
  assign irq_st_o = raw_o & ien_i;
  assign fiq_st_o = raw_o & fen_i;
  assign pt_st_o  = raw_o & pt_i;
endmodule

// File: rtl/lvl_intc_regs.sv
module lvl_intc_regs
  import lvl_intc_pkg::*;
#(
  parameter int unsigned N_LINES   = 32,
  parameter bit          SECONDARY = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [N_LINES-1:0]  raw_i,
  input  logic [N_LINES-1:0]  irq_st_i,
  input  logic [N_LINES-1:0]  fiq_st_i,
  output logic [N_LINES-1:0]  ien_o,
  output logic [N_LINES-1:0]  fen_o,
  output logic [N_LINES-1:0]  soft_o,
  output logic [N_LINES-1:0]  pt_o,
  output logic [DATA_W-1:0]   rdata_o
);
  reg_sel_e           sel;
  logic               wr, rd;
  logic [N_LINES-1:0] wmask;
  logic [N_LINES-1:0] ien_q, fen_q, soft_q;
  logic [N_LINES-1:0] rsel;

  assign sel   = decode_ofs(addr_i);
  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wmask = wdata_i[N_LINES-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
    end else if (wr && sel == SEL_IEN_SET) begin
      ien_q <= ien_q | wmask;
    end else if (wr && sel == SEL_IEN_CLR) begin
      ien_q <= ien_q & ~wmask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fen_q <= '0;
    end else if (wr && sel == SEL_FEN_SET) begin
      fen_q <= fen_q | wmask;
    end else if (wr && sel == SEL_FEN_CLR) begin
      fen_q <= fen_q & ~wmask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_q <= '0;
    end else if (wr && sel == SEL_SOFT_SET) begin
      soft_q <= soft_q | wmask;
    end else if (wr && sel == SEL_SOFT_CLR) begin
      soft_q <= soft_q & ~wmask;
    end
  end

  // pass-through mask exists only in the secondary variant; it shares the
  // fast-status offset on the write side
  generate
    if (SECONDARY) begin : g_pt
      logic [N_LINES-1:0] pt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pt_q <= '0;
        end else if (wr && sel == SEL_FIQ_STAT) begin
          pt_q <= wmask;
        end
      end
      assign pt_o = pt_q;
    end else begin : g_no_pt
      assign pt_o = '0;
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_IRQ_STAT:             rsel = irq_st_i;
      SEL_FIQ_STAT:             rsel = fiq_st_i;
      SEL_IRQ_RAW, SEL_FIQ_RAW: rsel = raw_i;
      default:                  rsel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= rd ? DATA_W'(rsel) : '0;
    end
  end

  assign ien_o  = ien_q;
  assign fen_o  = fen_q;
  assign soft_o = soft_q;
endmodule

// File: rtl/lvl_intc_outreg.sv
module lvl_intc_outreg #(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_st_i,
  input  logic [N_LINES-1:0] fiq_st_i,
  input  logic [N_LINES-1:0] pt_st_i,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [N_LINES-1:0] passthru_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      fiq_o      <= 1'b0;
      passthru_o <= '0;
    end else begin
      irq_o      <= |irq_st_i;
      fiq_o      <= |fiq_st_i;
      passthru_o <= pt_st_i;
    end
  end
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
  import lvl_intc_pkg::*;
#(
  parameter int unsigned        N_LINES    = 32,
  parameter logic [N_LINES-1:0] VALID_MASK = '1,
  parameter bit                 SECONDARY  = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_LINES-1:0]  src_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o,
  output logic                fiq_o,
  output logic [N_LINES-1:0]  passthru_o
);
  logic [N_LINES-1:0] ien_q, fen_q, soft_q, pt_q;
  logic [N_LINES-1:0] raw_st, irq_st, fiq_st, pt_st;

  lvl_intc_regs #(
    .N_LINES   (N_LINES),
    .SECONDARY (SECONDARY)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .raw_i    (raw_st),
    .irq_st_i (irq_st),
    .fiq_st_i (fiq_st),
    .ien_o    (ien_q),
    .fen_o    (fen_q),
    .soft_o   (soft_q),
    .pt_o     (pt_q),
    .rdata_o  (rdata_o)
  );

  lvl_intc_status #(
    .N_LINES    (N_LINES),
    .VALID_MASK (VALID_MASK)
  ) u_status (
    .src_i    (src_i),
    .soft_i   (soft_q),
    .ien_i    (ien_q),
    .fen_i    (fen_q),
    .pt_i     (pt_q),
    .raw_o    (raw_st),
    .irq_st_o (irq_st),
    .fiq_st_o (fiq_st),
    .pt_st_o  (pt_st)
  );

  lvl_intc_outreg #(
    .N_LINES (N_LINES)
  ) u_outreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_st_i   (irq_st),
    .fiq_st_i   (fiq_st),
    .pt_st_i    (pt_st),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .passthru_o (passthru_o)
  );
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
  parameter int unsigned        N_LINES    = 32,
  parameter logic [N_LINES-1:0] VALID_MASK = '1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [7:0]         addr_i,
  input logic [31:0]        wdata_i,
  input logic [31:0]        rdata_o,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [N_LINES-1:0] passthru_o,
  input logic [N_LINES-1:0] ien_i,
  input logic [N_LINES-1:0] fen_i,
  input logic [N_LINES-1:0] raw_i,
  input logic [N_LINES-1:0] irq_st_i,
  input logic [N_LINES-1:0] fiq_st_i,
  input logic [N_LINES-1:0] pt_i
);
  assert_irq_lat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|irq_st_i));

  assert_fiq_lat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == $past(|fiq_st_i));

  assert_ien_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h08) |=>
      ((ien_i & $past(wdata_i[N_LINES-1:0])) == $past(wdata_i[N_LINES-1:0])));

  assert_ien_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h0C) |=>
      ((ien_i & $past(wdata_i[N_LINES-1:0])) == '0));

  assert_ien_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(ien_i));

  assert_fen_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h28) |=>
      ((fen_i & $past(wdata_i[N_LINES-1:0])) == $past(wdata_i[N_LINES-1:0])));

  assert_fen_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h2C) |=>
      ((fen_i & $past(wdata_i[N_LINES-1:0])) == '0));

  assert_raw_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && !we_i && addr_i == 8'h04) |-> rdata_o == 32'($past(raw_i)));

  assert_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (passthru_o & ~VALID_MASK) == '0);

  assert_pt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    passthru_o == $past(raw_i & pt_i));

  assert_rd_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(req_i && !we_i)) |-> rdata_o == '0);
endmodule

bind lvl_intc lvl_intc_chk #(
  .N_LINES    (N_LINES),
  .VALID_MASK (VALID_MASK)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .passthru_o (passthru_o),
  .ien_i      (ien_q),
  .fen_i      (fen_q),
  .raw_i      (raw_st),
  .irq_st_i   (irq_st),
  .fiq_st_i   (fiq_st),
  .pt_i       (pt_q)
);

// File: tb/lvl_intc_bench.sv
module lvl_intc_bench;
  localparam int unsigned NL = 8;
  localparam logic [NL-1:0] VM = 8'hDF;  // line 5 absent

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [NL-1:0] src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata_s, rdata_p;
  logic          irq_s, fiq_s, irq_p, fiq_p;
  logic [NL-1:0] pt_s, pt_p;

  int unsigned n_vec = 0, n_bad = 0;
  logic [NL-1:0] m_ien = '0, m_fen = '0, m_soft = '0, m_pt = '0;

  lvl_intc #(.N_LINES(NL), .VALID_MASK(VM), .SECONDARY(1'b1)) u_lvl_intc (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_s), .irq_o(irq_s),
    .fiq_o(fiq_s), .passthru_o(pt_s));

  lvl_intc #(.N_LINES(NL), .VALID_MASK(VM), .SECONDARY(1'b0)) u_lvl_intc_pri (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_p), .irq_o(irq_p),
    .fiq_o(fiq_p), .passthru_o(pt_p));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] raw_f();
    return (src | m_soft) & VM;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    case (a)
      8'h08: m_ien  = m_ien | d[NL-1:0];
      8'h0C: m_ien  = m_ien & ~d[NL-1:0];
      8'h10: m_soft = m_soft | d[NL-1:0];
      8'h14: m_soft = m_soft & ~d[NL-1:0];
      8'h20: m_pt   = d[NL-1:0];
      8'h28: m_fen  = m_fen | d[NL-1:0];
      8'h2C: m_fen  = m_fen & ~d[NL-1:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] ds, output logic [31:0] dp);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    ds = rdata_s; dp = rdata_p;
  endtask

  task automatic setup(input logic [NL-1:0] ie, input logic [NL-1:0] fe,
                       input logic [NL-1:0] sf, input logic [NL-1:0] pm);
    wr(8'h0C, 32'hFF); wr(8'h2C, 32'hFF); wr(8'h14, 32'hFF);
    wr(8'h08, 32'(ie)); wr(8'h28, 32'(fe)); wr(8'h10, 32'(sf)); wr(8'h20, 32'(pm));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ds, dp;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 irq", 32'(irq_s), 0); chk("R1 fiq", 32'(fiq_s), 0);
    chk("R1 pt", 32'(pt_s), 0);   chk("R1 rdata", rdata_s, 0);
    rst_ni = 1'b1;
    src = 8'hFF;
    rd(8'h00, ds, dp); chk("R1 ien cleared", ds, 0);
    rd(8'h20, ds, dp); chk("R1 fen cleared", ds, 0);
    rd(8'h04, ds, dp); chk("R2 raw", ds, 32'hDF); chk("R8 raw invalid", ds[5], 0);
    chk("R1 pt cleared", 32'(pt_s), 0);
    chk("R1 irq idle", 32'(irq_s), 0);

    // R3 set/clear isolation
    wr(8'h08, 32'h81); wr(8'h08, 32'h04); wr(8'h0C, 32'h01);
    rd(8'h00, ds, dp); chk("R3 ien set/clr", ds, 32'h84);
    // R4
    wr(8'h28, 32'h0F); wr(8'h2C, 32'h05);
    rd(8'h20, ds, dp); chk("R4 fen set/clr", ds, 32'h0A);
    chk("R5 pri fiq view", dp, 32'h0A);
    // R9 write-only / unmapped / misaligned read zero
    rd(8'h08, ds, dp); chk("R9 rd 08", ds, 0);
    rd(8'h0C, ds, dp); chk("R9 rd 0C", ds, 0);
    rd(8'h10, ds, dp); chk("R9 rd 10", ds, 0);
    rd(8'h14, ds, dp); chk("R9 rd 14", ds, 0);
    rd(8'h28, ds, dp); chk("R9 rd 28", ds, 0);
    rd(8'h2C, ds, dp); chk("R9 rd 2C", ds, 0);
    rd(8'h3C, ds, dp); chk("R9 rd 3C", ds, 0);
    rd(8'h01, ds, dp); chk("R9 rd misaligned", ds, 0);
    // R9 writes to read-only views ignored
    wr(8'h00, 32'hFF); wr(8'h04, 32'hFF); wr(8'h24, 32'hFF);
    rd(8'h00, ds, dp); chk("R9 ro write ignored", ds, 32'h84);
    src = 8'h00;
    rd(8'h04, ds, dp); chk("R9 raw unaffected", ds, 0);

    // R6 soft bits, R8 invalid soft line
    wr(8'h10, 32'h24);
    rd(8'h24, ds, dp); chk("R6/R8 soft set", ds, 32'h04);
    wr(8'h14, 32'h04);
    rd(8'h04, ds, dp); chk("R6 soft clr", ds, 0);

    // R7 latency: enable write with source already high
    wr(8'h0C, 32'hFF); wr(8'h2C, 32'hFF);
    src = 8'h02;
    @(negedge clk);
    wr(8'h08, 32'h02);
    chk("R7 irq not yet", 32'(irq_s), 0);
    @(negedge clk);
    chk("R7 irq one cycle", 32'(irq_s), 1);
    src = 8'h00;
    @(negedge clk);
    chk("R7 irq drops", 32'(irq_s), 0);

    // R10 pass-through
    wr(8'h20, 32'hF0);
    src = 8'hFF;
    @(negedge clk);
    chk("R10 passthru", 32'(pt_s), 32'hD0);
    chk("R10 primary passthru", 32'(pt_p), 0);

    // exhaustive source sweep under four configurations (R2 R5 R7 R8 R10)
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: setup(8'hFF, 8'h00, 8'h00, 8'hFF);
        1: setup(8'hA5, 8'h5A, 8'h00, 8'h0F);
        2: setup(8'h3C, 8'h3C, 8'h21, 8'hF0);
        default: setup(8'h00, 8'hFF, 8'h80, 8'h00);
      endcase
      for (int s = 0; s < 256; s++) begin
        src = 8'(s);
        rd(8'h04, ds, dp); chk("R2 sweep raw", ds, 32'(raw_f()));
        rd(8'h00, ds, dp); chk("R5 sweep irq view", ds, 32'(raw_f() & m_ien));
        chk("R5 pri irq view", dp, 32'(raw_f() & m_ien));
        rd(8'h20, ds, dp); chk("R5 sweep fiq view", ds, 32'(raw_f() & m_fen));
        chk("R7 irq", 32'(irq_s), 32'(|(raw_f() & m_ien)));
        chk("R7 fiq", 32'(fiq_s), 32'(|(raw_f() & m_fen)));
        chk("R7 pri irq", 32'(irq_p), 32'(|(raw_f() & m_ien)));
        chk("R10 sweep passthru", 32'(pt_s), 32'(raw_f() & m_pt));
        chk("R10 pri zero", 32'(pt_p), 0);
        chk("R8 passthru invalid", 32'(pt_s[5]), 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule